// File: doc/BRIEF.md
# Glitch-Free Clock Rate Selector

This block divides a 62.5 MHz reference clock down to one of two output rates. When the select input is low, the output runs at one quarter of the reference (15.625 MHz). When it is high, the output runs at one half (31.25 MHz). The select input normally comes from a control register bit. It may change at any time, including while the output clock is running.

A free-running divider counter produces both divided rates in phase. The select bit passes through a two-flop synchronizer. The synchronized value is applied only on the edge where the counter wraps to zero. At that point both divided clocks are low, so no high or low phase of the output is ever shortened below one reference period. The output comes straight from a flop, which keeps combinational glitches off it. An active-low asynchronous reset returns the block to the slow rate with the output held low.

Top module: `clk_rate_sel`

## Requirements
- R1: While rst_ni is low, clk_o is 0. After rst_ni rises, the block runs at the slow rate: clk_o is 0 after the first and second reference edges.
- R2: With the applied rate slow, clk_o repeats low, low, high, high over four reference cycles. Counting reference edges k from 1 after reset release, clk_o after edge k is high when ((k-1) mod 4) is 2 or 3.
- R3: With the applied rate fast, clk_o toggles on every reference edge. Its period is two reference cycles.
- R4: A divider counter counts from 0 after reset and advances once per reference edge. The applied rate is updated only on the edge where the counter goes from 3 to 0. That edge is edge k where k mod 4 is 0. It takes the value fast_sel_i had at the reference edge two edges earlier. Example: with the rate slow and fast_sel_i rising just after edge e (e mod 4 = 1), clk_o after edges e+1 through e+7 is 0,1,1,0,1,0,1.
- R5: Every high phase and every low phase of clk_o lasts either one or two reference cycles, including across rate changes.
- R6: In the reference cycle that follows a rate change, clk_o is low.
- R7: A pulse on fast_sel_i that is not captured at a rate-update point has no effect on clk_o. The example is a one-cycle pulse sampled only at an edge with k mod 4 = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_sel_i | input | 1 | Rate select: 0 selects one quarter, 1 selects one half of the reference |
| clk_o | output | 1 | Divided output clock |

## Verification
The hardest situations to reach are select changes that arrive at a chosen phase of the divider. These include a change sampled exactly two edges before a wrap, and a short pulse that falls between two update points. Neither can be seen from the ports, because the counter is internal. The stimulus therefore counts reference edges from reset release, which gives the counter phase. It then places select edges and one-cycle pulses at known residues modulo four. A table of hold lengths, including one-cycle holds, walks the select through many other alignments against a cycle model.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= 1'b0;
        else         ff_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b0;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
  parameter int CNT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wrap_o,
  output logic tap_fast_o,
  output logic tap_slow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // both taps low in the cycle after wrap
  assign wrap_o     = (cnt_q == CNT_MAX);
  assign tap_fast_o = cnt_q[0];
  assign tap_slow_o = cnt_q[CNT_W-1];
endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
  import clksel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_sync_i,
  input  logic  wrap_i,
  input  logic  tap_fast_i,
  input  logic  tap_slow_i,
  output rate_e rate_o,
  output logic  clk_o
);
  rate_e rate_q;
  logic  clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rate_q <= RATE_SLOW;
    else if (wrap_i) rate_q <= rate_e'(sel_sync_i);
  end

  // registered mux: output never sees a combinational select edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= (rate_q == RATE_FAST) ? tap_fast_i : tap_slow_i;
  end

  assign rate_o = rate_q;
  assign clk_o  = clk_q;

  AST_SWITCH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_q) |-> $past(wrap_i)); // R4

  AST_LOW_AFTER_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_q) |=> !clk_q); // R6

  AST_FAST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q == RATE_FAST && $past(rate_q) == RATE_FAST && $past(rate_q, 2) == RATE_FAST)
      |-> (clk_q != $past(clk_q))); // R3
endmodule

// File: rtl/clk_rate_sel.sv
module clk_rate_sel
  import clksel_pkg::*;
#(
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_sel_i,
  output logic clk_o
);
  logic  sel_sync;
  logic  wrap;
  logic  tap_fast;
  logic  tap_slow;
  rate_e rate;

  clksel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fast_sel_i),
    .q_o   (sel_sync)
  );

  clksel_div #(.CNT_W(CNT_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wrap_o    (wrap),
    .tap_fast_o(tap_fast),
    .tap_slow_o(tap_slow)
  );

  clksel_switch u_switch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_sync_i(sel_sync),
    .wrap_i    (wrap),
    .tap_fast_i(tap_fast),
    .tap_slow_i(tap_slow),
    .rate_o    (rate),
    .clk_o     (clk_o)
  );

  // slow tap is high in the wrap cycle once the slow rate has been held
  AST_SLOW_HIGH_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == RATE_SLOW && $past(rate) == RATE_SLOW && wrap) |-> clk_o); // R2

  AST_RESET_LOW: assert property (@(negedge clk_i)
    !rst_ni |-> !clk_o); // R1
endmodule

// File: tb/clk_rate_sel_tb.sv
module clk_rate_sel_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fast_sel_i = 1'b0;
  logic clk_o;

  int checks = 0;
  int fails = 0;
  int edge_cnt = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  clk_rate_sel u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fast_sel_i(fast_sel_i),
    .clk_o     (clk_o)
  );

  // cycle model built from R2..R4
  logic [1:0] m_cnt;
  logic m_s1, m_s2, m_act, m_out;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 2'd0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_act <= 1'b0; m_out <= 1'b0;
    end else begin
      m_s1  <= fast_sel_i;
      m_s2  <= m_s1;
      if (m_cnt == 2'd3) m_act <= m_s2;
      m_out <= m_act ? m_cnt[0] : m_cnt[1];
      m_cnt <= m_cnt + 2'd1;
    end
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_cnt <= 0;
    else         edge_cnt <= edge_cnt + 1;
  end

  // phase length monitor (R5)
  int run_len = 0;
  int run_bad = 0;
  logic prev_out = 1'b0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      run_len = 0;
    end else if (edge_cnt >= 3) begin
      if (clk_o == prev_out) run_len++;
      else                   run_len = 1;
      if (run_len > 2) run_bad++;
    end
    prev_out = clk_o;
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clk_o=%0b expected %0b (edge %0d)", req, act, exp, edge_cnt);
    end
  endtask

  task automatic align(input int res);
    @(negedge clk_i);
    while ((edge_cnt % 4) != res) @(negedge clk_i);
  endtask

  typedef struct packed {
    logic       sel;
    logic [7:0] len;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS[NVEC] = '{
    '{1'b1, 8'd12}, '{1'b0, 8'd9},  '{1'b1, 8'd5}, '{1'b0, 8'd3},
    '{1'b1, 8'd1},  '{1'b0, 8'd10}, '{1'b1, 8'd7}, '{1'b0, 8'd2},
    '{1'b1, 8'd2},  '{1'b0, 8'd6},  '{1'b1, 8'd4}, '{1'b0, 8'd11}
  };

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic seq[8];
    int   trans;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1", clk_o, 1'b0);
    rst_ni = 1'b1;
    // R1/R2: slow pattern 0,0,1,1 per edge from release
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk_i);
      check(k <= 2 ? "R1" : "R2", clk_o, (((k - 1) % 4) >= 2) ? 1'b1 : 1'b0);
    end

    // R4/R6: select rising just after edge e, e mod 4 = 1
    align(1);
    fast_sel_i = 1'b1;
    begin
      logic exp_seq[7] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      for (int i = 0; i < 7; i++) begin
        @(negedge clk_i);
        check(i == 3 ? "R6" : "R4", clk_o, exp_seq[i]);
      end
    end

    // R3: fast steady toggles every edge
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 6; i++) begin
      logic last;
      last = clk_o;
      @(negedge clk_i);
      check("R3", clk_o, ~last);
    end

    // table walk against model (R4, R6)
    for (int v = 0; v < NVEC; v++) begin
      int bad;
      logic a, e;
      bad = 0;
      fast_sel_i = VECS[v].sel;
      for (int c = 0; c < int'(VECS[v].len); c++) begin
        @(negedge clk_i);
        if (clk_o !== m_out && bad == 0) begin a = clk_o; e = m_out; end
        if (clk_o !== m_out) bad++;
      end
      checks++;
      if (bad != 0) begin
        fails++;
        $display("FAIL R4 vector %0d: clk_o=%0b expected %0b", v, a, e);
      end
    end

    // return to slow and settle
    fast_sel_i = 1'b0;
    repeat (12) @(negedge clk_i);

    // R7: one-cycle pulse sampled only at an edge with k mod 4 = 3
    align(2);
    fast_sel_i = 1'b1;
    @(negedge clk_i);
    fast_sel_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      seq[i] = clk_o;
      check("R7", clk_o, m_out);
    end
    trans = 0;
    for (int i = 1; i < 8; i++) if (seq[i] != seq[i-1]) trans++;
    checks++;
    if (trans > 4) begin
      fails++;
      $display("FAIL R7: transitions=%0d expected <=4", trans);
    end

    // R1: reset mid-run while fast is selected
    fast_sel_i = 1'b1;
    repeat (12) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", clk_o, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R1", clk_o, 1'b0);
    rst_ni = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_i);
      check(k <= 2 ? "R1" : "R4", clk_o, k <= 2 ? 1'b0 : m_out);
    end

    // R5: phase lengths over the whole run
    checks++;
    if (run_bad != 0) begin
      fails++;
      $display("FAIL R5: over-long phases=%0d expected 0", run_bad);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule